// File: doc/BRIEF.md
# Multi-width microprocessor bus pixel assembler

This block takes write cycles from an asynchronous microprocessor bus and turns them into normalized 18-bit pixels for the internal pixel path. Two bus styles are supported. In the split-strobe style, a write ends on the rising edge of an active-low write strobe; a separate read strobe marks reads. In the enable style, a single active-high enable qualifies each cycle, a direction line selects read or write, and the write is taken on the falling edge of the enable. Both styles have an active-low chip select and a register-select line. Register-select low marks a command byte; high marks pixel data.

The bus may be 8, 9, 16 or 18 lines wide. Colour data may be 16-bit (5-6-5) or 18-bit (6-6-6), and its parts may arrive least significant or most significant first. The block counts the transfers each pixel needs for the selected mode. It places each transfer at its bit position and emits one pixel pulse when the last part arrives. A 5-6-5 pixel is widened to 6-6-6 by copying each red and blue component's top bit into a new low bit. Command bytes come out on their own strobe. Every data transfer also raises a data strobe. The mode inputs are held static while chip select is asserted.

The pixel output is a one-cycle valid pulse with no ready input. An asynchronous bus cannot be stalled, so the sink must accept every pulse. Pulses are at least several clocks apart, because each one follows a strobe edge through the synchronizer.

Top module: `mpu_pixel_assembler`

## Requirements
- R1: While reset is asserted, and after it until the first write, pix_valid, cmd_strobe and dat_strobe are 0.
- R2: A write's results appear on the outputs for exactly one cycle. That cycle is the third rising clock edge after the qualifying strobe edge, and nothing appears one edge earlier.
- R3: With bus_68=1, a write is taken on the falling edge of wr_e while rd_rw=0 and cs_n=0. A falling edge with rd_rw=1 is a read and produces no output.
- R4: A write with rs=0 pulses cmd_strobe with cmd_byte = din[7:0] and no dat_strobe. A write with rs=1 pulses dat_strobe.
- R5: With 5-6-5 data (depth_666=0) on a 16-line bus (bus_width=01), each write yields one pixel. Input c[15:0] becomes {c[15:11],c[15],c[10:5],c[4:0],c[4]}.
- R6: With 5-6-5 data on an 8-line bus (bus_width=11), a pixel takes two writes. With msb_first=0 the low byte c[7:0] comes first; with msb_first=1 the high byte comes first.
- R7: With 6-6-6 data on an 8-line bus, a pixel takes three writes of p[7:0], p[15:8] and p[17:16] (on din[1:0]). They arrive in that order when msb_first=0 and in reverse when msb_first=1.
- R8: With 6-6-6 data on a 9-line bus (bus_width=10), a pixel takes two halves p[8:0] and p[17:9]. The low half comes first when msb_first=0.
- R9: With 6-6-6 data on a 16-line bus, a pixel takes p[15:0] and then p[17:16] (on din[1:0]) when msb_first=0, or the reverse order when msb_first=1.
- R10: With 6-6-6 data on an 18-line bus (bus_width=00), each write yields pixel din[17:0].
- R11: 5-6-5 data on a 9-line or 18-line bus is illegal. mode_err is then 1, data writes still pulse dat_strobe, and no pixel is produced.
- R12: The part counter returns to the first part when cs_n goes high, or when a command is written, so a partial pixel is discarded.
- R13: With bus_68=0, a pulse of rd_rw (the read strobe) produces no output.
- R14: Bus lines above the selected width are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_68 | input | 1 | 1: enable-style bus, 0: split-strobe bus |
| bus_width | input | 2 | 00: 18 lines, 01: 16, 10: 9, 11: 8 |
| depth_666 | input | 1 | 0: 5-6-5 data, 1: 6-6-6 data |
| msb_first | input | 1 | 0: least significant part first, 1: most significant first |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | 0: command, 1: data |
| wr_e | input | 1 | Write strobe (active low) or enable (active high) |
| rd_rw | input | 1 | Read strobe (active low) or direction (1 = read) |
| din | input | 18 | Bus data lines |
| pix_valid | output | 1 | One-cycle pulse per assembled pixel |
| pix_data | output | 18 | Assembled pixel {R6,G6,B6} |
| cmd_strobe | output | 1 | One-cycle pulse per command byte |
| cmd_byte | output | 8 | Last command byte |
| dat_strobe | output | 1 | One-cycle pulse per data write |
| mode_err | output | 1 | Illegal width and depth combination |

## Verification
A strobe edge needs two synchronizer flops and one output register. Its results therefore show on the third rising edge after the edge and stay for one cycle. Each transfer task releases the strobe on a falling clock edge and counts rising edges from that point. It samples once one edge early, where nothing may show, then at the due cycle, then one cycle later, where the pulse must have cleared. Between steps, mode changes are made with chip select high, so the synchronizers settle before the next transfer.

// File: rtl/mpa_pkg.sv
package mpa_pkg;
  localparam int PIX_W = 18;

  typedef enum logic [1:0] {
    BW18 = 2'b00,
    BW16 = 2'b01,
    BW9  = 2'b10,
    BW8  = 2'b11
  } bus_w_e;

  function automatic logic [4:0] lane_width(bus_w_e w);
    case (w)
      BW18:    return 5'd18;
      BW16:    return 5'd16;
      BW9:     return 5'd9;
      default: return 5'd8;
    endcase
  endfunction

  function automatic logic [1:0] parts_for(bus_w_e w, logic d666);
    if (d666) begin
      case (w)
        BW8:     return 2'd3;
        BW9:     return 2'd2;
        BW16:    return 2'd2;
        default: return 2'd1;
      endcase
    end
    return (w == BW8) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic mode_bad(bus_w_e w, logic d666);
    return !d666 && (w == BW9 || w == BW18);
  endfunction

  function automatic logic [PIX_W-1:0] widen565(logic [15:0] c);
    return {c[15:11], c[15], c[10:5], c[4:0], c[4]};
  endfunction
endpackage

// File: rtl/mpa_sync.sv
module mpa_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[g] <= '1;
      else if (g == 0) st[g] <= d;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/mpa_strobe_decode.sv
module mpa_strobe_decode #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_68,
  input  logic cs_n,
  input  logic rs,
  input  logic wr_e,
  input  logic rd_rw,
  output logic wr_evt,
  output logic wr_cmd,
  output logic cs_idle
);
  logic [3:0]      s;
  logic            prev_wr;
  logic [STAGES:0] primed;
  logic            s_cs, s_rs, s_wr, s_rw;

  mpa_sync #(.W(4), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, rs, wr_e, rd_rw}), .q(s)
  );

  assign {s_cs, s_rs, s_wr, s_rw} = s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_wr <= 1'b1;
      primed  <= '0;
    end else begin
      prev_wr <= s_wr;
      primed  <= {primed[STAGES-1:0], 1'b1};
    end
  end

  logic rise, fall;
  assign rise    = s_wr & ~prev_wr;
  assign fall    = ~s_wr & prev_wr;
  assign wr_evt  = primed[STAGES] & ~s_cs & (bus_68 ? (fall & ~s_rw) : rise);
  assign wr_cmd  = ~s_rs;
  assign cs_idle = s_cs;
endmodule

// File: rtl/mpa_packer.sv
module mpa_packer
  import mpa_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_width,
  input  logic             depth_666,
  input  logic             msb_first,
  input  logic [PIX_W-1:0] din,
  input  logic             wr_evt,
  input  logic             wr_cmd,
  input  logic             cs_idle,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_data,
  output logic             cmd_strobe,
  output logic [CMD_W-1:0] cmd_byte,
  output logic             dat_strobe,
  output logic             mode_err
);
  bus_w_e           bw;
  logic [1:0]       n_parts, idx, k;
  logic [4:0]       lw;
  logic [5:0]       shift;
  logic [PIX_W-1:0] mask, lane, acc, acc_n;
  logic [2*PIX_W-1:0] placed;
  logic             last;

  always_comb begin
    bw      = bus_w_e'(bus_width);
    n_parts = parts_for(bw, depth_666);
    lw      = lane_width(bw);
    mask    = {PIX_W{1'b1}} >> (5'(PIX_W) - lw);
    lane    = din & mask;
    k       = msb_first ? (n_parts - 2'd1 - idx) : idx;
    shift   = 6'(k) * 6'(lw);
    placed  = {{PIX_W{1'b0}}, lane} << shift;
    acc_n   = ((idx == 2'd0) ? '0 : acc) | placed[PIX_W-1:0];
    last    = (idx == n_parts - 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      acc        <= '0;
      pix_valid  <= 1'b0;
      pix_data   <= '0;
      cmd_strobe <= 1'b0;
      cmd_byte   <= '0;
      dat_strobe <= 1'b0;
      mode_err   <= 1'b0;
    end else begin
      pix_valid  <= 1'b0;
      cmd_strobe <= 1'b0;
      dat_strobe <= 1'b0;
      mode_err   <= mode_bad(bw, depth_666);
      if (cs_idle) begin
        idx <= '0;
      end else if (wr_evt) begin
        if (wr_cmd) begin
          cmd_strobe <= 1'b1;
          cmd_byte   <= din[CMD_W-1:0];
          idx        <= '0;
        end else begin
          dat_strobe <= 1'b1;
          if (!mode_err) begin
            if (last) begin
              pix_valid <= 1'b1;
              pix_data  <= depth_666 ? acc_n : widen565(acc_n[15:0]);
              idx       <= '0;
            end else begin
              acc <= acc_n;
              idx <= idx + 2'd1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/mpu_pixel_assembler.sv
module mpu_pixel_assembler
  import mpa_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CMD_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_68,
  input  logic [1:0]       bus_width,
  input  logic             depth_666,
  input  logic             msb_first,
  input  logic             cs_n,
  input  logic             rs,
  input  logic             wr_e,
  input  logic             rd_rw,
  input  logic [PIX_W-1:0] din,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_data,
  output logic             cmd_strobe,
  output logic [CMD_W-1:0] cmd_byte,
  output logic             dat_strobe,
  output logic             mode_err
);
  logic wr_evt, wr_cmd, cs_idle;

  mpa_strobe_decode #(.STAGES(SYNC_STAGES)) u_decode (
    .clk(clk), .rst_n(rst_n), .bus_68(bus_68), .cs_n(cs_n), .rs(rs),
    .wr_e(wr_e), .rd_rw(rd_rw),
    .wr_evt(wr_evt), .wr_cmd(wr_cmd), .cs_idle(cs_idle)
  );

  mpa_packer #(.CMD_W(CMD_W)) u_packer (
    .clk(clk), .rst_n(rst_n), .bus_width(bus_width), .depth_666(depth_666),
    .msb_first(msb_first), .din(din), .wr_evt(wr_evt), .wr_cmd(wr_cmd),
    .cs_idle(cs_idle), .pix_valid(pix_valid), .pix_data(pix_data),
    .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte), .dat_strobe(dat_strobe),
    .mode_err(mode_err)
  );
endmodule

// File: rtl/mpa_checker.sv
module mpa_checker (
  input logic clk,
  input logic rst_n,
  input logic pix_valid,
  input logic cmd_strobe,
  input logic dat_strobe,
  input logic mode_err
);
  // R1: outputs quiet while reset is held
  always @(posedge clk) begin
    if (!rst_n) begin
      p_quiet_in_reset_r1: assert (!pix_valid && !cmd_strobe && !dat_strobe);
    end
  end

  // R2: pixel pulse lasts one cycle
  p_pix_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid);

  // R2: command pulse lasts one cycle
  p_cmd_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  // R4: a write is either command or data, never both
  p_cmd_dat_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_strobe && dat_strobe));

  // R4: every pixel comes from a data write
  p_pix_with_dat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> dat_strobe);

  // R11: no pixel while the mode is illegal
  p_err_blocks_pix_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_err && $past(mode_err)) |-> !pix_valid);
endmodule

bind mpu_pixel_assembler mpa_checker u_mpa_checker (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .cmd_strobe(cmd_strobe),
  .dat_strobe(dat_strobe), .mode_err(mode_err)
);

// File: tb/mpu_pixel_assembler_bench.sv
module mpu_pixel_assembler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_68 = 1'b0;
  logic [1:0]  bus_width = 2'b01;
  logic        depth_666 = 1'b0;
  logic        msb_first = 1'b0;
  logic        cs_n = 1'b1;
  logic        rs = 1'b1;
  logic        wr_e = 1'b1;
  logic        rd_rw = 1'b1;
  logic [17:0] din = '0;
  logic        pix_valid, cmd_strobe, dat_strobe, mode_err;
  logic [17:0] pix_data;
  logic [7:0]  cmd_byte;

  int nchk = 0;
  int nerr = 0;
  logic        s_early, s_pix, s_cmd, s_dat, s_after;
  logic [17:0] s_pd;
  logic [7:0]  s_cb;

  always #4 clk = ~clk;

  mpu_pixel_assembler u_mpu_pixel_assembler (
    .clk(clk), .rst_n(rst_n), .bus_68(bus_68), .bus_width(bus_width),
    .depth_666(depth_666), .msb_first(msb_first), .cs_n(cs_n), .rs(rs),
    .wr_e(wr_e), .rd_rw(rd_rw), .din(din), .pix_valid(pix_valid),
    .pix_data(pix_data), .cmd_strobe(cmd_strobe), .cmd_byte(cmd_byte),
    .dat_strobe(dat_strobe), .mode_err(mode_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input logic b68, input logic [1:0] w, input logic d, input logic m);
    @(negedge clk);
    cs_n = 1'b1;
    bus_68 = b68;
    wr_e = b68 ? 1'b0 : 1'b1;
    rd_rw = 1'b1;
    bus_width = w;
    depth_666 = d;
    msb_first = m;
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_release();
    @(negedge clk);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic xfer(input logic rs_v, input logic [17:0] d);
    @(negedge clk);
    cs_n = 1'b0; rs = rs_v; din = d;
    if (bus_68) rd_rw = 1'b0;
    @(negedge clk);
    wr_e = bus_68 ? 1'b1 : 1'b0;
    repeat (4) @(negedge clk);
    wr_e = bus_68 ? 1'b0 : 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    s_early = pix_valid | cmd_strobe | dat_strobe;
    @(posedge clk); @(negedge clk);
    s_pix = pix_valid; s_pd = pix_data; s_cmd = cmd_strobe;
    s_cb = cmd_byte; s_dat = dat_strobe;
    @(negedge clk);
    s_after = pix_valid | cmd_strobe | dat_strobe;
    if (bus_68) rd_rw = 1'b1;
  endtask

  task automatic read_pulse(input string tag);
    @(negedge clk);
    cs_n = 1'b0; rs = 1'b1; din = 18'h3FFFF;
    if (bus_68) begin
      rd_rw = 1'b1; wr_e = 1'b1;
    end else rd_rw = 1'b0;
    repeat (4) @(negedge clk);
    if (bus_68) wr_e = 1'b0; else rd_rw = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    s_early = pix_valid | cmd_strobe | dat_strobe;
    @(posedge clk); @(negedge clk);
    chk(tag, {29'b0, s_early, pix_valid | cmd_strobe, dat_strobe}, 32'h0);
    cs_release();
  endtask

  function automatic logic [17:0] exp565(input logic [15:0] c);
    return {c[15:11], c[15], c[10:5], c[4:0], c[4]};
  endfunction

  task automatic send_pixel(input string tag, input logic [17:0] w);
    int lw, n, bits;
    logic [17:0] mask, part, expv;
    case (bus_width)
      2'b00: lw = 18;
      2'b01: lw = 16;
      2'b10: lw = 9;
      default: lw = 8;
    endcase
    bits = depth_666 ? 18 : 16;
    n = (bits + lw - 1) / lw;
    mask = 18'((1 << lw) - 1);
    expv = depth_666 ? w : exp565(w[15:0]);
    for (int i = 0; i < n; i++) begin
      int k;
      k = msb_first ? (n - 1 - i) : i;
      part = (w >> (k * lw)) & mask;
      xfer(1'b1, part | ~mask);
      chk({tag, " dat_strobe"}, 32'(s_dat), 32'h1);
      if (i < n - 1) chk({tag, " no early pixel"}, 32'(s_pix), 32'h0);
      else begin
        chk({tag, " R2 timing"}, {30'b0, s_early, s_after}, 32'h0);
        chk({tag, " pix_valid"}, 32'(s_pix), 32'h1);
        chk({tag, " pix_data"}, 32'(s_pd), 32'(expv));
      end
    end
    cs_release();
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1 in reset", {29'b0, pix_valid, cmd_strobe, dat_strobe}, 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 after reset", {29'b0, pix_valid, cmd_strobe, dat_strobe}, 32'h0);
  endtask

  task automatic test_split_modes();
    set_mode(1'b0, 2'b01, 1'b0, 1'b0);
    send_pixel("R5 16bus 565", 18'h0F81F);
    send_pixel("R5 16bus 565 b", 18'h07A35);
    set_mode(1'b0, 2'b11, 1'b0, 1'b0);
    send_pixel("R6 R14 8bus lsb", 18'h0C3A5);
    set_mode(1'b0, 2'b11, 1'b0, 1'b1);
    send_pixel("R6 8bus msb", 18'h05B1E);
    set_mode(1'b0, 2'b11, 1'b1, 1'b0);
    send_pixel("R7 8bus lsb", 18'h2D3C7);
    set_mode(1'b0, 2'b11, 1'b1, 1'b1);
    send_pixel("R7 8bus msb", 18'h1A5F0);
    set_mode(1'b0, 2'b10, 1'b1, 1'b0);
    send_pixel("R8 9bus lsb", 18'h3A1C5);
    set_mode(1'b0, 2'b10, 1'b1, 1'b1);
    send_pixel("R8 9bus msb", 18'h0B6E9);
    set_mode(1'b0, 2'b01, 1'b1, 1'b0);
    send_pixel("R9 16bus lsb", 18'h2F00D);
    set_mode(1'b0, 2'b01, 1'b1, 1'b1);
    send_pixel("R9 16bus msb", 18'h1BEEF);
    set_mode(1'b0, 2'b00, 1'b1, 1'b0);
    send_pixel("R10 18bus", 18'h3C0F1);
  endtask

  task automatic test_illegal();
    set_mode(1'b0, 2'b10, 1'b0, 1'b0);
    chk("R11 err 9bus 565", 32'(mode_err), 32'h1);
    xfer(1'b1, 18'h1FF);
    chk("R11 dat still strobes", 32'(s_dat), 32'h1);
    xfer(1'b1, 18'h0AA);
    chk("R11 no pixel 9bus", 32'(s_pix), 32'h0);
    cs_release();
    set_mode(1'b0, 2'b00, 1'b0, 1'b0);
    chk("R11 err 18bus 565", 32'(mode_err), 32'h1);
    xfer(1'b1, 18'h12345);
    chk("R11 no pixel 18bus", 32'(s_pix), 32'h0);
    cs_release();
    set_mode(1'b0, 2'b00, 1'b1, 1'b0);
    chk("R11 err clears", 32'(mode_err), 32'h0);
  endtask

  task automatic test_restart();
    set_mode(1'b0, 2'b11, 1'b0, 1'b0);
    xfer(1'b1, 18'h0AA);
    cs_release();
    send_pixel("R12 after cs release", 18'h09C33);
    xfer(1'b1, 18'h055);
    xfer(1'b0, 18'h3FF3C);
    chk("R4 cmd_strobe", 32'(s_cmd), 32'h1);
    chk("R4 cmd_byte", 32'(s_cb), 32'h3C);
    chk("R4 no dat on cmd", {30'b0, s_dat, s_pix}, 32'h0);
    send_pixel("R12 after command", 18'h0E1D2);
  endtask

  task automatic test_reads_and_68();
    set_mode(1'b0, 2'b00, 1'b1, 1'b0);
    read_pulse("R13 split read ignored");
    set_mode(1'b1, 2'b11, 1'b1, 1'b1);
    send_pixel("R3 enable bus 8bus msb", 18'h2468A);
    read_pulse("R3 enable read ignored");
    xfer(1'b0, 18'h000C1);
    chk("R3 R4 enable cmd", {23'b0, s_cmd, s_cb}, {23'b0, 1'b1, 8'hC1});
    cs_release();
    set_mode(1'b1, 2'b01, 1'b0, 1'b0);
    send_pixel("R3 enable 16bus 565", 18'h0FFE0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    test_reset();
    test_split_modes();
    test_illegal();
    test_restart();
    test_reads_and_68();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule